// File: doc/BRIEF.md
# Grid-Cell Non-Maxima Suppressor

This block takes a stream of corner scores, one pixel per accepted beat, in raster order. It keeps only the scores that are local maxima within a square window of side 2·RADIUS+1. From those survivors it selects a single winner in each cell of a fixed rectangular grid. For every cell it produces one record holding the winning score and its x and y position. This caps the number of features per frame and spreads them evenly over the image.

Suppression and cell selection are done in a single pass. The block keeps a few line buffers so that each score can be compared against its neighbours while the stream is still arriving. It keeps a running best per column lane for each cell column. When a cell's final line has been decided, a pairwise halving tree folds the lane bests into the cell winner. A window must extend RADIUS pixels past the right and bottom edges of the image. The block scans those padding positions itself, and it drops `in_ready` while it does so.

The grid is CELL_W = LANES·W_MULT columns by CELL_H = H_BASE·2^(PYR_LEVELS-1) lines, both divided by 2^LEVEL. Reported coordinates are multiplied by 2^LEVEL, so that results from a reduced-resolution level land on the full-resolution grid.

Top module: `grid_nms`

## Requirements
- R1: A positive score is a survivor only if no score in its (2·RADIUS+1)² window is strictly larger. Equal neighbours do not suppress each other. Positions outside the image count as 0.
- R2: Each grid cell yields exactly one record, carrying the largest surviving score in that cell and its position. Cells at the right and bottom edges may be partial.
- R3: When survivors tie on score, the winner is the one with the smaller y. If y is also equal, the winner is the one with the smaller x.
- R4: A cell with no positive survivor yields a record with out_score 0, out_x 0, out_y 0 and out_empty 1. Any other record has out_empty 0.
- R5: Records come out as single-cycle out_valid pulses. They are ordered by cell row, then by cell column from left to right. No record of a cell row appears before RADIUS further lines below that cell row have been accepted.
- R6: out_x and out_y equal the image position multiplied by 2^LEVEL. Cell dimensions are divided by 2^LEVEL.
- R7: When in_valid is low while in_ready is high, the scan holds. in_ready is low for RADIUS beats after each line and for RADIUS whole padding lines after the final line. Scores presented while in_ready is low are ignored.
- R8: Frames follow each other with no gap. Nothing from the previous frame affects the records of the next one.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Score beat present |
| in_score | input | SCORE_W | Corner score, raster order |
| in_ready | output | 1 | Block accepts a beat this cycle |
| out_valid | output | 1 | Cell record pulse |
| out_score | output | SCORE_W | Winning score of the cell |
| out_x | output | XW+LEVEL | Winner column, full-resolution |
| out_y | output | YW+LEVEL | Winner line, full-resolution |
| out_empty | output | 1 | Cell had no positive survivor |

## Verification
The bench aims at the following failure modes:
- A diagonal neighbour that sits across both a horizontal and a vertical cell boundary. A design that limits the window to the cell would report the weaker peak instead of the next-best survivor.
- Peaks on the image border. If padding were not treated as zero, these peaks would be dropped.
- Ties of three kinds: between lanes on the same line, between lines in the same column, and on a plateau of two adjacent equal scores. A wrong compare direction would report the later position.
- Partial streaming of a frame. This shows that no record leaves early.
- Back-to-back random frames driven with junk beats during padding. These expose line-buffer residue and the acceptance of scores while in_ready is low.
- A second instance at a reduced level. It checks the halved cell size and the doubled coordinates.

// File: rtl/grid_nms.sv
`timescale 1ns/1ps
module grid_nms #(
  parameter int IMG_W      = 64,
  parameter int IMG_H      = 16,
  parameter int SCORE_W    = 8,
  parameter int RADIUS     = 1,
  parameter int LANES      = 32,
  parameter int W_MULT     = 1,
  parameter int H_BASE     = 4,
  parameter int PYR_LEVELS = 2,
  parameter int LEVEL      = 0,
  localparam int SW  = IMG_W + RADIUS,
  localparam int SH  = IMG_H + RADIUS,
  localparam int XW  = $clog2(SW + 1),
  localparam int YW  = $clog2(SH + 1),
  localparam int OXW = XW + LEVEL,
  localparam int OYW = YW + LEVEL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [SCORE_W-1:0] in_score,
  output logic               in_ready,
  output logic               out_valid,
  output logic [SCORE_W-1:0] out_score,
  output logic [OXW-1:0]     out_x,
  output logic [OYW-1:0]     out_y,
  output logic               out_empty
);
  localparam int CELL_W = (LANES * W_MULT) >> LEVEL;
  localparam int CELL_H = (H_BASE << (PYR_LEVELS - 1)) >> LEVEL;
  localparam int LN     = (CELL_W < LANES) ? CELL_W : LANES;
  localparam int DEPTH  = $clog2(LN);
  localparam int NCX    = (IMG_W + CELL_W - 1) / CELL_W;
  localparam int CW     = (NCX > 1) ? $clog2(NCX) : 1;
  localparam int LW     = (LN > 1) ? $clog2(LN) : 1;
  localparam int D      = 2 * RADIUS + 1;
  localparam int AW     = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  logic [XW-1:0] sx;
  logic [YW-1:0] sy;
  logic in_img, step;
  logic [SCORE_W-1:0] v;

  assign in_img   = (sx < XW'(IMG_W)) && (sy < YW'(IMG_H));
  assign in_ready = in_img;
  assign step     = in_img ? in_valid : 1'b1;
  assign v        = in_img ? in_score : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sx <= '0;
      sy <= '0;
    end else if (step) begin
      if (sx == XW'(SW - 1)) begin
        sx <= '0;
        sy <= (sy == YW'(SH - 1)) ? '0 : sy + 1'b1;
      end else begin
        sx <= sx + 1'b1;
      end
    end
  end

  // line buffers: lb[0] is the previous line
  logic [SCORE_W-1:0] lb [2*RADIUS][IMG_W];
  logic [AW-1:0] sxi;
  logic col_in;
  assign sxi    = sx[AW-1:0];
  assign col_in = sx < XW'(IMG_W);

  always_ff @(posedge clk) begin
    if (step && col_in) begin
      lb[0][sxi] <= v;
      for (int j = 1; j < 2*RADIUS; j++) lb[j][sxi] <= lb[j-1][sxi];
    end
  end

  logic [SCORE_W-1:0] nc  [D];
  logic [SCORE_W-1:0] win [D][D-1];
  logic [SCORE_W-1:0] m   [D][D];

  always_comb begin
    for (int r = 0; r < D; r++) nc[r] = '0;
    if (col_in) begin
      nc[D-1] = v;
      for (int j = 0; j < 2*RADIUS; j++) nc[D-2-j] = lb[j][sxi];
    end
  end

  always_ff @(posedge clk) begin
    if (step)
      for (int r = 0; r < D; r++)
        for (int c = 0; c < D-1; c++)
          win[r][c] <= (c == D-2) ? nc[r] : win[r][c+1];
  end

  always_comb begin
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++) begin
        m[r][c] = (c == D-1) ? nc[r] : win[r][c];
        if (int'(sx) + c < 2*RADIUS || int'(sy) + r < 2*RADIUS) m[r][c] = '0;
      end
  end

  // window test, one ring per distance from the centre
  logic [SCORE_W-1:0] cs;
  logic [RADIUS-1:0]  ring_ok;
  logic center_ok, cand;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;

  assign cs        = m[RADIUS][RADIUS];
  assign center_ok = step && (int'(sx) >= RADIUS) && (int'(sy) >= RADIUS);
  assign cx        = sx - XW'(RADIUS);
  assign cy        = sy - YW'(RADIUS);

  always_comb begin
    ring_ok = '1;
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++) begin
        int dr, dc, dd;
        dr = (r > RADIUS) ? r - RADIUS : RADIUS - r;
        dc = (c > RADIUS) ? c - RADIUS : RADIUS - c;
        dd = (dr > dc) ? dr : dc;
        if (dd > 0 && m[r][c] > cs) ring_ok[dd-1] = 1'b0;
      end
  end
  assign cand = center_ok && (&ring_ok) && (cs != '0);

  // per-lane running best for each cell column of the current cell row
  logic [CW-1:0] ccol;
  logic [LW-1:0] lane;
  logic last_col, last_row, cell_done;
  assign ccol      = CW'(int'(cx) / CELL_W);
  assign lane      = LW'(int'(cx) % LN);
  assign last_col  = (int'(cx) % CELL_W == CELL_W - 1) || (int'(cx) == IMG_W - 1);
  assign last_row  = (int'(cy) % CELL_H == CELL_H - 1) || (int'(cy) == IMG_H - 1);
  assign cell_done = center_ok && last_col && last_row;

  logic [SCORE_W-1:0] ls [NCX][LN];
  logic [XW-1:0]      lx [NCX][LN];
  logic [YW-1:0]      ly [NCX][LN];
  logic               fl_go;
  logic [CW-1:0]      fl_cell;
  logic [SCORE_W-1:0] cur;
  logic               upd;

  assign cur = (fl_go && fl_cell == ccol) ? '0 : ls[ccol][lane];
  assign upd = cand && (cs > cur);

  // halving tree over the lanes of the finished cell
  logic [SCORE_W-1:0] ts [DEPTH+1][LN];
  logic [XW-1:0]      tx [DEPTH+1][LN];
  logic [YW-1:0]      ty [DEPTH+1][LN];

  always_comb begin
    for (int k = 0; k <= DEPTH; k++)
      for (int i = 0; i < LN; i++) begin
        ts[k][i] = '0; tx[k][i] = '0; ty[k][i] = '0;
      end
    for (int i = 0; i < LN; i++) begin
      ts[0][i] = ls[fl_cell][i];
      tx[0][i] = lx[fl_cell][i];
      ty[0][i] = ly[fl_cell][i];
    end
    for (int k = 1; k <= DEPTH; k++)
      for (int i = 0; i < (LN >> k); i++) begin
        int b;
        logic bw;
        b  = i + (LN >> k);
        bw = (ts[k-1][b] > ts[k-1][i]) ||
             ((ts[k-1][b] == ts[k-1][i]) &&
              ((ty[k-1][b] < ty[k-1][i]) ||
               ((ty[k-1][b] == ty[k-1][i]) && (tx[k-1][b] < tx[k-1][i]))));
        ts[k][i] = bw ? ts[k-1][b] : ts[k-1][i];
        tx[k][i] = bw ? tx[k-1][b] : tx[k-1][i];
        ty[k][i] = bw ? ty[k-1][b] : ty[k-1][i];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCX; c++)
        for (int l = 0; l < LN; l++) begin
          ls[c][l] <= '0; lx[c][l] <= '0; ly[c][l] <= '0;
        end
      fl_go     <= 1'b0;
      fl_cell   <= '0;
      out_valid <= 1'b0;
      out_score <= '0;
      out_x     <= '0;
      out_y     <= '0;
      out_empty <= 1'b0;
    end else begin
      fl_go     <= cell_done;
      fl_cell   <= ccol;
      out_valid <= fl_go;
      if (fl_go) begin
        out_score <= ts[DEPTH][0];
        out_x     <= OXW'(tx[DEPTH][0]) << LEVEL;
        out_y     <= OYW'(ty[DEPTH][0]) << LEVEL;
        out_empty <= (ts[DEPTH][0] == '0);
        for (int l = 0; l < LN; l++) begin
          ls[fl_cell][l] <= '0; lx[fl_cell][l] <= '0; ly[fl_cell][l] <= '0;
        end
      end
      if (upd) begin
        ls[ccol][lane] <= cs;
        lx[ccol][lane] <= cx;
        ly[ccol][lane] <= cy;
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> ($stable(sx) && $stable(sy)));

  // R7
  pad_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !($stable(sx) && $stable(sy)));

  // R6
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_x < OXW'(IMG_W << LEVEL)) && (out_y < OYW'(IMG_H << LEVEL))));

  // R2
  out_cell_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_empty) |-> ((int'(out_x >> LEVEL) / CELL_W) == int'($past(fl_cell))));

  for (genvar gc = 0; gc < NCX; gc++) begin : g_mono
    for (genvar gl = 0; gl < LN; gl++) begin : g_lane
      // R2
      lane_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_go && fl_cell == CW'(gc)) |=> (ls[gc][gl] >= $past(ls[gc][gl])));
    end
  end
endmodule

// File: tb/grid_nms_tb.sv
`timescale 1ns/1ps
module grid_nms_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int img [16][64];

  logic       drv_valid = 1'b0;
  logic [7:0] drv_score = '0;
  int         sel = 0;

  logic       v0, v1, r0, r1, rdy;
  logic       ov0, ov1, oe0, oe1;
  logic [7:0] os0, os1;
  logic [6:0] ox0, ox1;
  logic [4:0] oy0, oy1;

  assign v0  = drv_valid && (sel == 0);
  assign v1  = drv_valid && (sel == 1);
  assign rdy = (sel == 1) ? r1 : r0;

  grid_nms u_dut (
    .clk(clk), .rst(rst), .in_valid(v0), .in_score(drv_score), .in_ready(r0),
    .out_valid(ov0), .out_score(os0), .out_x(ox0), .out_y(oy0), .out_empty(oe0));

  grid_nms #(.IMG_W(32), .IMG_H(8), .LEVEL(1)) u_lvl (
    .clk(clk), .rst(rst), .in_valid(v1), .in_score(drv_score), .in_ready(r1),
    .out_valid(ov1), .out_score(os1), .out_x(ox1), .out_y(oy1), .out_empty(oe1));

  int rs [2][64];
  int rx [2][64];
  int ry [2][64];
  int re [2][64];
  int rn [2];
  initial begin rn[0] = 0; rn[1] = 0; end
  always @(negedge clk) begin
    if (ov0 && rn[0] < 64) begin
      rs[0][rn[0]] = os0; rx[0][rn[0]] = ox0; ry[0][rn[0]] = oy0; re[0][rn[0]] = oe0;
      rn[0] = rn[0] + 1;
    end
    if (ov1 && rn[1] < 64) begin
      rs[1][rn[1]] = os1; rx[1][rn[1]] = ox1; ry[1][rn[1]] = oy1; re[1][rn[1]] = oe1;
      rn[1] = rn[1] + 1;
    end
  end

  int es [16];
  int ex [16];
  int ey [16];
  int ee [16];
  int en;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 64; x++) img[y][x] = 0;
  endtask

  function automatic int pix(input int x, input int y, input int w, input int h);
    if (x < 0 || y < 0 || x >= w || y >= h) return 0;
    return img[y][x];
  endfunction

  task automatic build_expect(input int w, input int h, input int cw, input int ch, input int lvl);
    en = 0;
    for (int by = 0; by < (h + ch - 1) / ch; by++)
      for (int bx = 0; bx < (w + cw - 1) / cw; bx++) begin
        int best, bxp, byp;
        best = 0; bxp = 0; byp = 0;
        for (int y = by * ch; y < by * ch + ch && y < h; y++)
          for (int x = bx * cw; x < bx * cw + cw && x < w; x++) begin
            bit keep;
            keep = img[y][x] > 0;
            for (int dy = -1; dy <= 1; dy++)
              for (int dx = -1; dx <= 1; dx++)
                if (pix(x + dx, y + dy, w, h) > img[y][x]) keep = 0;
            if (keep && img[y][x] > best) begin
              best = img[y][x]; bxp = x; byp = y;
            end
          end
        es[en] = best; ex[en] = bxp << lvl; ey[en] = byp << lvl; ee[en] = (best == 0);
        en++;
      end
  endtask

  task automatic stream_rows(input int w, input int y0, input int y1, input bit junk);
    int cnt;
    cnt = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = 0; x < w; x++) begin
        @(negedge clk);
        while (!rdy) begin
          drv_valid = junk; drv_score = 8'hFF;
          @(negedge clk);
        end
        drv_valid = 1'b1; drv_score = 8'(img[y][x]);
        cnt++;
        if (cnt % 7 == 0) begin
          @(negedge clk);
          drv_valid = 1'b0;
        end
      end
  endtask

  task automatic settle(input int n, input bit junk);
    repeat (n) begin
      @(negedge clk);
      drv_valid = junk && !rdy;
      drv_score = 8'hFF;
    end
    drv_valid = 1'b0;
  endtask

  task automatic compare(input int s, input int base, input string req);
    chk(rn[s] - base == en, req, "record count", rn[s] - base, en);
    for (int i = 0; i < en && base + i < rn[s]; i++) begin
      chk(rs[s][base+i] == es[i], req, $sformatf("cell %0d score", i), rs[s][base+i], es[i]);
      chk(rx[s][base+i] == ex[i], req, $sformatf("cell %0d x", i), rx[s][base+i], ex[i]);
      chk(ry[s][base+i] == ey[i], req, $sformatf("cell %0d y", i), ry[s][base+i], ey[i]);
      chk(re[s][base+i] == ee[i], req, $sformatf("cell %0d empty", i), re[s][base+i], ee[i]);
    end
  endtask

  task automatic frame0(input bit junk, input string req);
    int base;
    sel = 0;
    base = rn[0];
    stream_rows(64, 0, 15, junk);
    settle(150, junk);
    build_expect(64, 16, 32, 8, 0);
    compare(0, base, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ov0 == 1'b0, "R9", "out_valid after reset", int'(ov0), 0);
    chk(r0 == 1'b1, "R9", "in_ready after reset", int'(r0), 1);
  endtask

  task automatic t_empty();
    clear_img();
    frame0(1'b0, "R4");
  endtask

  task automatic t_peaks();
    clear_img();
    img[3][5] = 50; img[6][20] = 40; img[2][40] = 70; img[12][10] = 90;
    frame0(1'b0, "R2");
    chk(rs[0][rn[0]-3] == 70, "R2", "cell 1 winner", rs[0][rn[0]-3], 70);
  endtask

  task automatic t_cross();
    clear_img();
    img[7][31] = 60; img[8][32] = 61; img[3][3] = 10;
    img[1][40] = 33; img[1][41] = 33;
    img[15][0] = 25; img[15][63] = 80;
    frame0(1'b1, "R1");
    chk(rs[0][rn[0]-4] == 10, "R1", "diagonal suppression across cells", rs[0][rn[0]-4], 10);
    chk(rx[0][rn[0]-3] == 40, "R3", "plateau picks smaller x", rx[0][rn[0]-3], 40);
    chk(rx[0][rn[0]-2] == 0, "R1", "left border peak survives", rx[0][rn[0]-2], 0);
  endtask

  task automatic t_tie();
    clear_img();
    img[2][10] = 44; img[1][20] = 44;
    img[4][50] = 44; img[4][36] = 44;
    img[9][5] = 44;  img[14][5] = 44;
    frame0(1'b0, "R3");
    chk(ry[0][rn[0]-4] == 1, "R3", "tie picks smaller y", ry[0][rn[0]-4], 1);
    chk(rx[0][rn[0]-3] == 36, "R3", "tie picks smaller x", rx[0][rn[0]-3], 36);
    chk(ry[0][rn[0]-2] == 9, "R3", "same-lane tie picks smaller y", ry[0][rn[0]-2], 9);
  endtask

  task automatic t_band();
    int base;
    clear_img();
    img[7][3] = 20; img[5][50] = 30; img[9][9] = 12;
    sel = 0;
    base = rn[0];
    stream_rows(64, 0, 7, 1'b0);
    settle(20, 1'b0);
    chk(rn[0] - base == 0, "R5", "no record before the lines below arrive", rn[0] - base, 0);
    stream_rows(64, 8, 8, 1'b0);
    settle(10, 1'b0);
    chk(rn[0] - base == 2, "R5", "first cell row emitted", rn[0] - base, 2);
    stream_rows(64, 9, 15, 1'b0);
    settle(150, 1'b0);
    build_expect(64, 16, 32, 8, 0);
    compare(0, base, "R5");
  endtask

  task automatic t_random();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int f = 0; f < 3; f++) begin
      clear_img();
      for (int y = 0; y < 16; y++)
        for (int x = 0; x < 64; x++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          img[y][x] = (lf[9:8] == 2'b00) ? 0 : int'(lf[7:0]);
        end
      frame0(1'b1, (f == 0) ? "R7" : "R8");
    end
  endtask

  task automatic t_level();
    int base;
    clear_img();
    img[1][3] = 77; img[2][20] = 66; img[6][30] = 55; img[5][2] = 9; img[5][3] = 99;
    sel = 1;
    base = rn[1];
    stream_rows(32, 0, 7, 1'b1);
    settle(80, 1'b1);
    build_expect(32, 8, 16, 4, 1);
    compare(1, base, "R6");
    chk(rx[1][base+1] == 40, "R6", "scaled x of cell 1", rx[1][base+1], 40);
    sel = 0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_empty();
    t_peaks();
    t_cross();
    t_tie();
    t_band();
    t_random();
    t_level();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule